// File: doc/BRIEF.md
# Parallel Flash Identification Sequencer

This block works out which parallel NOR flash device sits on a byte-wide bus. It runs a fixed command script on a simple request/acknowledge port. The script starts with a software reset and then unlocks the device's identification mode. It reads the manufacturer and device codes, leaves identification mode, and reads the same locations again as ordinary memory. A separate bus port module turns each request into real bus timing. This block decides only what is written or read and how long to wait between accesses.

A single-cycle `start` latches the configuration:

- the unlock address mask;
- a long or short reset;
- the timing mode with its entry and exit waits in microseconds;
- the two expected codes.

While the probe runs, `busy` stays high. At the end, `done` pulses for one cycle and the result outputs are loaded at the same time. Results include the extended codes, a match flag and an odd-parity check on the manufacturer byte. Two further flags tell whether each code equals what the array holds once identification mode is off. That last check helps the caller reject a false identification read from a device that ignored the commands.

Top module: `flash_id_prober`

## Requirements
- R1: After reset, `bus_req`, `busy`, `done`, `id_match`, `parity_err`, both array flags and both code outputs are 0.
- R2: Every command write uses address 0x5555 or 0x2AAA ANDed with the selected mask. `mask_sel` 0 and 3 select 0xFFFF, 1 selects 0x07FF, and 2 selects 0x0FFF.
- R3: The reset phase writes 0xAA to the first unlock address, then 0x55 to the second, then 0xF0 to the first. The first two writes are left out when `long_reset` is 0. Identification entry then writes 0xAA, 0x55 and 0x90 to the first, second and first unlock addresses.
- R4: In identification mode the block reads offset 0 (manufacturer) and then offset 1 (device). A byte equal to 0x7F then causes one extra read: offset 0x100 for the manufacturer and offset 0x101 for the device, taken in that order. The extended code is {first byte, second byte} when the first byte is 0x7F, and {0x00, first byte} otherwise.
- R5: After identification, the block repeats the reset-phase writes as an exit phase, then performs the same reads again. `mfr_is_array` and `model_is_array` are set when the extended value read back equals the captured code.
- R6: `parity_err` is 1 when bits 7:0 of the manufacturer code have an even number of ones.
- R7: `id_match` is 1 only when both extended codes equal `exp_mfr` and `exp_model`. It and all other results are loaded with a `done` pulse that lasts exactly one cycle.
- R8: When the entry wait is nonzero, the block waits that long before the first access, after each entry unlock write (10 µs) and after the 0x90 write. When the exit wait is nonzero, it waits 10 µs after each reset or exit unlock write and the exit wait after each 0xF0 write. One µs is `TICKS_PER_US` clocks.
- R9: `timing_mode` 0 uses `enter_us` and `exit_us` as given. Mode 1 removes every wait. Modes 2 and 3 use 10000 µs for entry and 40 µs for exit.
- R10: Only one bus request is open at a time. `bus_req` together with its address, data and direction holds until `bus_ack`, and is raised only while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a probe when idle |
| mask_sel | input | 2 | Unlock address mask select |
| long_reset | input | 1 | 1: three-write reset and exit, 0: single 0xF0 write |
| timing_mode | input | 2 | 0 programmed, 1 no waits, 2/3 default waits |
| enter_us | input | UW | Entry wait in µs (mode 0) |
| exit_us | input | UW | Exit wait in µs (mode 0) |
| exp_mfr | input | 16 | Expected extended manufacturer code |
| exp_model | input | 16 | Expected extended device code |
| bus_req | output | 1 | Access request, held until acknowledged |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | AW | Access address |
| bus_wdata | output | 8 | Write data |
| bus_ack | input | 1 | Access complete |
| bus_rdata | input | 8 | Read data, valid with `bus_ack` |
| busy | output | 1 | Probe in progress |
| done | output | 1 | One-cycle completion pulse |
| mfr_id | output | 16 | Extended manufacturer code |
| model_id | output | 16 | Extended device code |
| id_match | output | 1 | Both codes equal the expected values |
| parity_err | output | 1 | Manufacturer low byte fails odd parity |
| mfr_is_array | output | 1 | Manufacturer code equals array content |
| model_is_array | output | 1 | Device code equals array content |

## Verification
The bench builds the block with `TICKS_PER_US` = 2 and keeps the 16-bit address and delay widths. With that clock ratio, the 10 µs unlock gap is 20 cycles and the 10 ms default entry wait is 20000 cycles. Every wait, including the default-mode run, therefore fits inside the bench and is measured between acknowledged accesses. A device model in the bench answers identification reads only after a correct masked unlock sequence. This makes the address masks, the short and long reset forms, and the continuation reads visible in the logged access trace.

// File: rtl/flash_probe_pkg.sv
package flash_probe_pkg;

  typedef enum logic [4:0] {
    ST_WAIT_ENTER, ST_RST_AA, ST_RST_55, ST_RST_F0,
    ST_ENT_AA, ST_ENT_55, ST_ENT_90,
    ST_ID_M, ST_ID_D, ST_ID_MX, ST_ID_DX,
    ST_EX_AA, ST_EX_55, ST_EX_F0,
    ST_RB_M, ST_RB_D, ST_RB_MX, ST_RB_DX,
    ST_FINISH
  } step_e;

  typedef enum logic [1:0] {PH_IDLE, PH_STEP, PH_BUS, PH_GAP} phase_e;

  localparam logic [7:0]  CONT_CODE = 8'h7F;
  localparam logic [7:0]  CMD_UNLK1 = 8'hAA;
  localparam logic [7:0]  CMD_UNLK2 = 8'h55;
  localparam logic [7:0]  CMD_RESET = 8'hF0;
  localparam logic [7:0]  CMD_IDENT = 8'h90;
  localparam logic [15:0] UNLK_A1   = 16'h5555;
  localparam logic [15:0] UNLK_A2   = 16'h2AAA;

  function automatic logic [15:0] sel_mask(input logic [1:0] s);
    case (s)
      2'd1:    return 16'h07FF;
      2'd2:    return 16'h0FFF;
      default: return 16'hFFFF;
    endcase
  endfunction

  function automatic logic [15:0] ext_id(input logic [7:0] b0, input logic [7:0] b1);
    return (b0 == CONT_CODE) ? {b0, b1} : {8'h00, b0};
  endfunction

endpackage

// File: rtl/probe_gap_timer.sv
module probe_gap_timer #(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [CW-1:0] cycles,
  output logic          fin
);
  logic          running;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      cnt     <= '0;
      fin     <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        running <= 1'b1;
        cnt     <= cycles - 1'b1;
      end else if (running) begin
        if (cnt == '0) begin
          running <= 1'b0;
          fin     <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/probe_bus_port.sv
module probe_bus_port #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_wdata,
  input  logic          bus_ack,
  input  logic [7:0]    bus_rdata,
  output logic          fin,
  output logic [7:0]    rd_byte
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      fin       <= 1'b0;
      rd_byte   <= '0;
    end else begin
      fin <= 1'b0;
      if (!bus_req && go) begin
        bus_req   <= 1'b1;
        bus_we    <= we;
        bus_addr  <= addr;
        bus_wdata <= wdata;
      end else if (bus_req && bus_ack) begin
        bus_req <= 1'b0;
        fin     <= 1'b1;
        if (!bus_we) rd_byte <= bus_rdata;
      end
    end
  end
endmodule

// File: rtl/flash_id_prober.sv
module flash_id_prober #(
  parameter int AW           = 16,
  parameter int UW           = 16,
  parameter int TICKS_PER_US = 100,
  parameter int UNLOCK_US    = 10,
  parameter int DEF_ENTER_US = 10000,
  parameter int DEF_EXIT_US  = 40
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [1:0]    mask_sel,
  input  logic          long_reset,
  input  logic [1:0]    timing_mode,
  input  logic [UW-1:0] enter_us,
  input  logic [UW-1:0] exit_us,
  input  logic [15:0]   exp_mfr,
  input  logic [15:0]   exp_model,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_wdata,
  input  logic          bus_ack,
  input  logic [7:0]    bus_rdata,
  output logic          busy,
  output logic          done,
  output logic [15:0]   mfr_id,
  output logic [15:0]   model_id,
  output logic          id_match,
  output logic          parity_err,
  output logic          mfr_is_array,
  output logic          model_is_array
);
  import flash_probe_pkg::*;

  localparam int TW = $clog2(TICKS_PER_US + 1);
  localparam int CW = UW + TW;
  localparam logic [CW-1:0] UNL_CYC = CW'(UNLOCK_US * TICKS_PER_US);

  step_e         step;
  phase_e        phase;
  logic [AW-1:0] mask_q;
  logic          long_q;
  logic [UW-1:0] enter_q, exit_q;
  logic [15:0]   expm_q, expd_q;
  logic [7:0]    m0, m1, d0, d1, f0, f1, g0, g1;

  logic [CW-1:0] enter_cyc, exit_cyc;
  assign enter_cyc = CW'(enter_q) * CW'(TICKS_PER_US);
  assign exit_cyc  = CW'(exit_q)  * CW'(TICKS_PER_US);

  logic [AW-1:0] a1m, a2m;
  assign a1m = AW'(UNLK_A1) & mask_q;
  assign a2m = AW'(UNLK_A2) & mask_q;

  // Decode of the current script step.
  logic          op_act, op_bus, op_we;
  logic [AW-1:0] op_addr;
  logic [7:0]    op_data;
  logic [CW-1:0] op_gap;
  logic [CW-1:0] gap_rst_unl, gap_ent_unl;
  assign gap_rst_unl = (exit_cyc  != '0) ? UNL_CYC : '0;
  assign gap_ent_unl = (enter_cyc != '0) ? UNL_CYC : '0;

  always_comb begin
    op_act  = 1'b1;
    op_bus  = 1'b1;
    op_we   = 1'b0;
    op_addr = '0;
    op_data = '0;
    op_gap  = '0;
    case (step)
      ST_WAIT_ENTER: begin op_bus = 1'b0; op_gap = enter_cyc; op_act = (enter_cyc != '0); end
      ST_RST_AA, ST_EX_AA: begin
        op_act = long_q; op_we = 1'b1; op_addr = a1m; op_data = CMD_UNLK1; op_gap = gap_rst_unl;
      end
      ST_RST_55, ST_EX_55: begin
        op_act = long_q; op_we = 1'b1; op_addr = a2m; op_data = CMD_UNLK2; op_gap = gap_rst_unl;
      end
      ST_RST_F0, ST_EX_F0: begin op_we = 1'b1; op_addr = a1m; op_data = CMD_RESET; op_gap = exit_cyc; end
      ST_ENT_AA: begin op_we = 1'b1; op_addr = a1m; op_data = CMD_UNLK1; op_gap = gap_ent_unl; end
      ST_ENT_55: begin op_we = 1'b1; op_addr = a2m; op_data = CMD_UNLK2; op_gap = gap_ent_unl; end
      ST_ENT_90: begin op_we = 1'b1; op_addr = a1m; op_data = CMD_IDENT; op_gap = enter_cyc; end
      ST_ID_M, ST_RB_M: op_addr = AW'(16'h0000);
      ST_ID_D, ST_RB_D: op_addr = AW'(16'h0001);
      ST_ID_MX: begin op_act = (m0 == CONT_CODE); op_addr = AW'(16'h0100); end
      ST_ID_DX: begin op_act = (d0 == CONT_CODE); op_addr = AW'(16'h0101); end
      ST_RB_MX: begin op_act = (f0 == CONT_CODE); op_addr = AW'(16'h0100); end
      ST_RB_DX: begin op_act = (g0 == CONT_CODE); op_addr = AW'(16'h0101); end
      default: begin op_act = 1'b0; op_bus = 1'b0; end
    endcase
  end

  logic bp_go, bp_fin, tm_go, tm_fin;
  logic [7:0] rd_byte;
  assign bp_go = (phase == PH_STEP) && (step != ST_FINISH) && op_act && op_bus;
  assign tm_go = ((phase == PH_STEP) && (step != ST_FINISH) && op_act && !op_bus) ||
                 ((phase == PH_BUS) && bp_fin && (op_gap != '0));

  probe_bus_port #(.AW(AW)) u_port (
    .clk(clk), .rst(rst), .go(bp_go), .we(op_we), .addr(op_addr), .wdata(op_data),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .fin(bp_fin), .rd_byte(rd_byte)
  );

  probe_gap_timer #(.CW(CW)) u_gap (
    .clk(clk), .rst(rst), .go(tm_go), .cycles(op_gap), .fin(tm_fin)
  );

  logic [15:0] mfr_w, model_w, mfr_rb, model_rb;
  assign mfr_w    = ext_id(m0, m1);
  assign model_w  = ext_id(d0, d1);
  assign mfr_rb   = ext_id(f0, f1);
  assign model_rb = ext_id(g0, g1);

  always_ff @(posedge clk) begin
    if (rst) begin
      step <= ST_WAIT_ENTER;  phase <= PH_IDLE;
      mask_q <= '0;  long_q <= 1'b0;  enter_q <= '0;  exit_q <= '0;
      expm_q <= '0;  expd_q <= '0;
      m0 <= '0; m1 <= '0; d0 <= '0; d1 <= '0;
      f0 <= '0; f1 <= '0; g0 <= '0; g1 <= '0;
      busy <= 1'b0;  done <= 1'b0;
      mfr_id <= '0;  model_id <= '0;  id_match <= 1'b0;
      parity_err <= 1'b0;  mfr_is_array <= 1'b0;  model_is_array <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase)
        PH_IDLE: if (start) begin
          mask_q <= AW'(sel_mask(mask_sel));
          long_q <= long_reset;
          case (timing_mode)
            2'd0:    begin enter_q <= enter_us;          exit_q <= exit_us; end
            2'd1:    begin enter_q <= '0;                exit_q <= '0; end
            default: begin enter_q <= UW'(DEF_ENTER_US); exit_q <= UW'(DEF_EXIT_US); end
          endcase
          expm_q <= exp_mfr;
          expd_q <= exp_model;
          step   <= ST_WAIT_ENTER;
          phase  <= PH_STEP;
          busy   <= 1'b1;
        end
        PH_STEP: begin
          if (step == ST_FINISH) begin
            mfr_id         <= mfr_w;
            model_id       <= model_w;
            id_match       <= (mfr_w == expm_q) && (model_w == expd_q);
            parity_err     <= ~^mfr_w[7:0];
            mfr_is_array   <= (mfr_w == mfr_rb);
            model_is_array <= (model_w == model_rb);
            done  <= 1'b1;
            busy  <= 1'b0;
            phase <= PH_IDLE;
          end else if (!op_act) begin
            step <= step_e'(step + 5'd1);
          end else if (op_bus) begin
            phase <= PH_BUS;
          end else begin
            phase <= PH_GAP;
          end
        end
        PH_BUS: if (bp_fin) begin
          case (step)
            ST_ID_M:  m0 <= rd_byte;
            ST_ID_MX: m1 <= rd_byte;
            ST_ID_D:  d0 <= rd_byte;
            ST_ID_DX: d1 <= rd_byte;
            ST_RB_M:  f0 <= rd_byte;
            ST_RB_MX: f1 <= rd_byte;
            ST_RB_D:  g0 <= rd_byte;
            ST_RB_DX: g1 <= rd_byte;
            default: ;
          endcase
          if (op_gap != '0) begin
            phase <= PH_GAP;
          end else begin
            step  <= step_e'(step + 5'd1);
            phase <= PH_STEP;
          end
        end
        PH_GAP: if (tm_fin) begin
          step  <= step_e'(step + 5'd1);
          phase <= PH_STEP;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/probe_checker.sv
module probe_checker #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_req,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic          bus_ack,
  input logic          busy,
  input logic          done,
  input logic [AW-1:0] mask_q
);
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

  assert_req_in_probe_R10: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> busy);

  assert_write_masked_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_we) |-> ((bus_addr & ~mask_q) == '0));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_quiet_bus_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (!bus_req && !busy));
endmodule

bind flash_id_prober probe_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_ack(bus_ack), .busy(busy), .done(done), .mask_q(mask_q)
);

// File: tb/sim_flash_id_prober.sv
module sim_flash_id_prober;
  localparam int AW = 16;
  localparam int UW = 16;
  localparam int TPU = 2;
  localparam int SLACK = 8;
  localparam int MAXEV = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [1:0] mask_sel = '0;
  logic long_reset = 1'b0;
  logic [1:0] timing_mode = '0;
  logic [UW-1:0] enter_us = '0, exit_us = '0;
  logic [15:0] exp_mfr = '0, exp_model = '0;
  logic bus_req, bus_we, bus_ack = 1'b0;
  logic [AW-1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata = '0;
  logic busy, done, id_match, parity_err, mfr_is_array, model_is_array;
  logic [15:0] mfr_id, model_id;

  always #2 clk = ~clk;

  flash_id_prober #(.AW(AW), .UW(UW), .TICKS_PER_US(TPU)) u0 (
    .clk(clk), .rst(rst), .start(start), .mask_sel(mask_sel), .long_reset(long_reset),
    .timing_mode(timing_mode), .enter_us(enter_us), .exit_us(exit_us),
    .exp_mfr(exp_mfr), .exp_model(exp_model), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .busy(busy), .done(done), .mfr_id(mfr_id), .model_id(model_id), .id_match(id_match),
    .parity_err(parity_err), .mfr_is_array(mfr_is_array), .model_is_array(model_is_array)
  );

  int checks = 0, fails = 0, cyc = 0, start_cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Device model
  logic [7:0] dev_m0, dev_m1, dev_d0, dev_d1, arr0, arr1, arr100, arr101;
  logic [15:0] dmask = 16'hFFFF;
  logic id_mode = 1'b0;
  int stage = 0;

  // Observed and expected access traces
  logic ev_we[MAXEV];  logic [15:0] ev_addr[MAXEV];  logic [7:0] ev_data[MAXEV];  int ev_cyc[MAXEV];
  int n_ev = 0;
  logic ex_we[MAXEV];  logic [15:0] ex_addr[MAXEV];  logic [7:0] ex_data[MAXEV];  int ex_gap[MAXEV];
  int n_ex = 0, pg = 0;

  function automatic logic [7:0] dev_read(input logic [15:0] a);
    if (id_mode)
      case (a) 16'h0: return dev_m0; 16'h1: return dev_d0; 16'h100: return dev_m1;
               16'h101: return dev_d1; default: return 8'hFF; endcase
    else
      case (a) 16'h0: return arr0; 16'h1: return arr1; 16'h100: return arr100;
               16'h101: return arr101; default: return 8'hFF; endcase
  endfunction

  always @(negedge clk) begin
    if (bus_ack) bus_ack = 1'b0;
    else if (bus_req) begin
      bus_ack = 1'b1;
      if (n_ev < MAXEV) begin
        ev_we[n_ev] = bus_we; ev_addr[n_ev] = bus_addr;
        ev_data[n_ev] = bus_we ? bus_wdata : dev_read(bus_addr);
        ev_cyc[n_ev] = cyc;
      end
      n_ev++;
      if (bus_we) begin
        if (bus_wdata == 8'hF0) begin id_mode = 1'b0; stage = 0; end
        else if (stage == 0) stage = (bus_wdata == 8'hAA && bus_addr == (16'h5555 & dmask)) ? 1 : 0;
        else if (stage == 1) stage = (bus_wdata == 8'h55 && bus_addr == (16'h2AAA & dmask)) ? 2 : 0;
        else begin
          if (bus_wdata == 8'h90 && bus_addr == (16'h5555 & dmask)) id_mode = 1'b1;
          stage = 0;
        end
      end else bus_rdata = dev_read(bus_addr);
    end
  end

  function automatic logic [15:0] mask_of(input logic [1:0] s);
    case (s) 2'd1: return 16'h07FF; 2'd2: return 16'h0FFF; default: return 16'hFFFF; endcase
  endfunction

  function automatic logic [15:0] ext(input logic [7:0] b0, input logic [7:0] b1);
    return (b0 == 8'h7F) ? {b0, b1} : {8'h00, b0};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic add(input logic we, input logic [15:0] a, input logic [7:0] d);
    ex_we[n_ex] = we; ex_addr[n_ex] = a; ex_data[n_ex] = d; ex_gap[n_ex] = pg;
    pg = 0; n_ex++;
  endtask

  task automatic cmd_phase(input logic lr, input logic [15:0] m, input int ec);
    if (lr) begin
      add(1'b1, 16'h5555 & m, 8'hAA); pg = (ec != 0) ? 10 * TPU : 0;
      add(1'b1, 16'h2AAA & m, 8'h55); pg = (ec != 0) ? 10 * TPU : 0;
    end
    add(1'b1, 16'h5555 & m, 8'hF0); pg = ec;
  endtask

  task automatic build_expect(input logic lr, input logic [15:0] m, input int nc, input int xc);
    n_ex = 0; pg = nc;
    cmd_phase(lr, m, xc);
    add(1'b1, 16'h5555 & m, 8'hAA); pg = (nc != 0) ? 10 * TPU : 0;
    add(1'b1, 16'h2AAA & m, 8'h55); pg = (nc != 0) ? 10 * TPU : 0;
    add(1'b1, 16'h5555 & m, 8'h90); pg = nc;
    add(1'b0, 16'h0, dev_m0); add(1'b0, 16'h1, dev_d0);
    if (dev_m0 == 8'h7F) add(1'b0, 16'h100, dev_m1);
    if (dev_d0 == 8'h7F) add(1'b0, 16'h101, dev_d1);
    cmd_phase(lr, m, xc);
    add(1'b0, 16'h0, arr0); add(1'b0, 16'h1, arr1);
    if (arr0 == 8'h7F) add(1'b0, 16'h100, arr100);
    if (arr1 == 8'h7F) add(1'b0, 16'h101, arr101);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // One full probe with the current device contents, then all checks.
  task automatic run_probe(input logic [1:0] ms, input logic lr, input logic [1:0] tm,
                           input int eu, input int xu, input string treq);
    int nc, xc, t;
    logic [15:0] em, ed, rm, rd;
    bit ok;
    nc = (tm == 2'd0) ? eu * TPU : (tm == 2'd1) ? 0 : 10000 * TPU;
    xc = (tm == 2'd0) ? xu * TPU : (tm == 2'd1) ? 0 : 40 * TPU;
    build_expect(lr, mask_of(ms), nc, xc);
    em = ext(dev_m0, dev_m1); ed = ext(dev_d0, dev_d1);
    rm = ext(arr0, arr100);   rd = ext(arr1, arr101);
    @(negedge clk);
    dmask = mask_of(ms); id_mode = 1'b0; stage = 0; n_ev = 0;
    mask_sel = ms; long_reset = lr; timing_mode = tm;
    enter_us = UW'(eu); exit_us = UW'(xu);
    start = 1'b1; start_cyc = cyc;
    @(negedge clk); start = 1'b0;
    t = 0;
    while (!done && t < 60000) begin @(negedge clk); t++; end
    if (!done) begin
      check(1'b0, treq, "watchdog expired", 32'(t), 32'd60000);
      finish_run();
    end
    ok = (n_ev == n_ex);
    for (int i = 0; i < n_ex && i < MAXEV; i++)
      if (ev_we[i] != ex_we[i] || ev_addr[i] != ex_addr[i] || ev_data[i] != ex_data[i]) ok = 0;
    check(ok, "R2/R3/R4/R5", {"access trace ", treq}, 32'(n_ev), 32'(n_ex));
    ok = (n_ev == n_ex);
    for (int i = 0; i < n_ex && i < MAXEV && ok; i++) begin
      int dl;
      dl = ev_cyc[i] - ((i == 0) ? start_cyc : ev_cyc[i-1]);
      if (dl < ex_gap[i] || dl > ex_gap[i] + SLACK) begin
        ok = 0;
        check(1'b0, "R8/R9", {"gap ", treq}, 32'(dl), 32'(ex_gap[i]));
      end
    end
    if (ok) check(1'b1, "R8", "gaps", 0, 0);
    check(mfr_id == em, "R4", "manufacturer code", 32'(mfr_id), 32'(em));
    check(model_id == ed, "R4", "device code", 32'(model_id), 32'(ed));
    check(parity_err == ~^em[7:0], "R6", "parity flag", 32'(parity_err), 32'(~^em[7:0]));
    check(id_match == (em == exp_mfr && ed == exp_model), "R7", "match flag",
          32'(id_match), 32'(em == exp_mfr && ed == exp_model));
    check(mfr_is_array == (em == rm), "R5", "manufacturer array flag", 32'(mfr_is_array), 32'(em == rm));
    check(model_is_array == (ed == rd), "R5", "device array flag", 32'(model_is_array), 32'(ed == rd));
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R7", "done width", 32'(done), 0);
  endtask

  function automatic logic [7:0] rbyte();
    return (($urandom % 4) == 0) ? 8'h7F : 8'($urandom);
  endfunction

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED1234);
    dev_m0 = 8'h01; dev_m1 = 8'h00; dev_d0 = 8'hB5; dev_d1 = 8'h00;
    arr0 = 8'h11; arr1 = 8'h22; arr100 = 8'h33; arr101 = 8'h44;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(bus_req == 0 && busy == 0 && done == 0, "R1", "control outputs after reset",
          {29'd0, bus_req, busy, done}, 0);
    check(mfr_id == 0 && model_id == 0 && id_match == 0 && parity_err == 0 &&
          mfr_is_array == 0 && model_is_array == 0, "R1", "results after reset",
          {mfr_id, model_id}, 0);
    rst = 1'b0;
    @(negedge clk);

    // Long reset, full mask, no continuation, matching codes (R3)
    exp_mfr = 16'h0001; exp_model = 16'h00B5;
    run_probe(2'd0, 1'b1, 2'd0, 3, 2, "R3 long reset");
    // Short reset, 0x7FF mask, manufacturer continuation (R2, R4)
    dev_m0 = 8'h7F; dev_m1 = 8'h9D; dev_d0 = 8'h4C;
    exp_mfr = 16'h7F9D; exp_model = 16'h004C;
    run_probe(2'd1, 1'b0, 2'd0, 1, 4, "R2 short reset mask 7FF");
    // 0xFFF mask, device continuation, device mismatch (R7)
    dev_m0 = 8'hBF; dev_d0 = 8'h7F; dev_d1 = 8'h21;
    exp_mfr = 16'h00BF; exp_model = 16'h7F22;
    run_probe(2'd2, 1'b1, 2'd0, 2, 0, "R7 mismatch mask FFF");
    // Mask select 3, both continued, array equals codes (R5)
    dev_m0 = 8'h7F; dev_m1 = 8'h52; dev_d0 = 8'h7F; dev_d1 = 8'h0E;
    arr0 = 8'h7F; arr100 = 8'h52; arr1 = 8'h7F; arr101 = 8'h0E;
    exp_mfr = 16'h7F52; exp_model = 16'h7F0E;
    run_probe(2'd3, 1'b1, 2'd0, 0, 3, "R5 array equals codes");
    // Zero timing ignores programmed waits (R9)
    arr0 = 8'h12; arr1 = 8'h34;
    dev_m0 = 8'h03; dev_d0 = 8'h66;
    run_probe(2'd0, 1'b1, 2'd1, 50, 50, "R9 zero timing");
    // Even parity manufacturer byte (R6)
    dev_m0 = 8'h33; dev_d0 = 8'h10;
    run_probe(2'd1, 1'b1, 2'd0, 0, 0, "R6 parity");
    // Default timing (R9)
    dev_m0 = 8'hDA; dev_d0 = 8'h0B;
    run_probe(2'd0, 1'b0, 2'd2, 1, 1, "R9 default timing");

    // Random mix
    for (int k = 0; k < 12; k++) begin
      dev_m0 = rbyte(); dev_m1 = 8'($urandom); dev_d0 = rbyte(); dev_d1 = 8'($urandom);
      if (($urandom % 3) == 0) begin
        arr0 = dev_m0; arr100 = dev_m1; arr1 = dev_d0; arr101 = dev_d1;
      end else begin
        arr0 = rbyte(); arr100 = 8'($urandom); arr1 = rbyte(); arr101 = 8'($urandom);
      end
      if (($urandom % 2) == 0) begin
        exp_mfr = ext(dev_m0, dev_m1); exp_model = ext(dev_d0, dev_d1);
      end else begin
        exp_mfr = ext(dev_m0, dev_m1) ^ 16'(($urandom % 2) << 3); exp_model = 16'($urandom);
      end
      run_probe(2'($urandom), 1'($urandom), 2'($urandom % 2),
                int'($urandom % 12), int'($urandom % 12), "R4 random");
    end
    finish_run();
  end
endmodule